// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a general purpose I/O port of up to 32 pins, reached through a 32-bit word-addressed register interface. Software sets an output latch and a direction vector. For each, the interface offers a plain write, a bit-set alias and a bit-clear alias. Every pin also has its own configuration word. That word holds the pin's direction, an input-buffer disconnect bit, a pull selection and a drive mode. The direction bit is stored only once, so the port-wide direction view and each pin's configuration word always agree.

Each cycle, per-pin logic resolves the configuration, the latch bit and an external stimulus into three results. The external stimulus is a drive-enable and a drive-value per pin, which gives high, low or undriven. The results are an output enable with a level, the sampled input bit, and a short-circuit flag. Open-drain and open-source style drive modes let the driver through only at one latch level. A selected pull on a floating pin behaves like a driver: it sets both the pin and the sampled input. The resolved results are registered, so they are stable until a register write or a stimulus change alters the pin.

The register selector decoded from the address takes one of these values: SEL_NONE (unmapped), SEL_OUT, SEL_OUTSET, SEL_OUTCLR, SEL_IN, SEL_DIR, SEL_DIRSET, SEL_DIRCLR and SEL_CFG. Each write and each read takes the single branch named by the selector. No transition depends on history.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The output latch is at 0x504. A write there replaces the latch. A write to 0x508 ORs the data into it. A write to 0x50C clears every latch bit whose data bit is 1. A read of any of these three addresses returns the latch.
- R2: The direction vector follows the same replace, set and clear rules through 0x514, 0x518 and 0x51C. A read of any of these three addresses returns the vector, where bit n is pin n's direction.
- R3: The configuration word of pin n is at 0x700 + 4·n. Its fields are: bit 0 direction (1 = output), bit 1 input-buffer disconnect (1 = disconnected), bits 3:2 pull (1 = pull-down, 3 = pull-up, 0 or 2 = none) and bits 10:8 drive mode. Reads return these fields, and all other bits read as 0.
- R4: Any direction-vector write sets bit 0 of each pin's configuration word to that pin's new direction. A configuration-word write sets that pin's bit in the direction vector to bit 0 of the written data.
- R5: The driver is connected only when the direction is output. Drive modes 0–3 always connect it, modes 4–5 only while the latch bit is 1, and modes 6–7 only while it is 0. pin_oe shows the connection and pin_dat shows the latch bit, unless a pull stands in as described in R7.
- R6: With the input buffer disconnected and a pull selected, the pin's input bit is forced to the pull level. With no pull selected, the input bit takes the external value while the pin is driven, and otherwise holds.
- R7: With the input buffer connected and the pin undriven externally, a selected pull with no connected driver makes pin_oe 1 and pin_dat the pull level. A connected driver or pull then copies its level into the input bit. With neither, the input bit holds its value.
- R8: pin_short is 1 exactly when the input buffer is connected, the driver is connected, the pin is driven externally, and the external value differs from the latch bit.
- R9: With the input buffer connected and the pin driven externally, the input bit equals the external value.
- R10: After reset the latch, the input vector and the direction vector are 0, every configuration word reads 0x00000002, and pin_oe and pin_short are 0.
- R11: A read of any unmapped address returns 0 with bus_err high for that one read. Unaligned addresses and configuration slots beyond the pin count count as unmapped. A write to the input register at 0x510 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | Unmapped-read pulse, aligned with bus_rdata |
| ext_drv_en | input | NPINS | External drive present per pin |
| ext_drv_val | input | NPINS | External drive level per pin |
| pin_oe | output | NPINS | Resolved output enable per pin |
| pin_dat | output | NPINS | Resolved output level per pin |
| pin_short | output | NPINS | Driver conflict flag per pin |

## Verification
A register write takes effect on the clock edge that samples it. The resolved pin_oe, pin_dat, pin_short and input bit follow on the next edge. A read returns its data one edge after the strobe. A change of the external stimulus shows in the results on the first edge after the change. The bench drives every input and samples every output on the falling clock edge. After the last configuration write, it waits one more edge before it compares pin results. Before each combination in the sweep, it preloads the input bit through a forcing pull, so that the cases where the input bit holds have a known expected value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned REG_W = 32;

    localparam logic [11:0] OFS_OUT    = 12'h504;
    localparam logic [11:0] OFS_OUTSET = 12'h508;
    localparam logic [11:0] OFS_OUTCLR = 12'h50C;
    localparam logic [11:0] OFS_IN     = 12'h510;
    localparam logic [11:0] OFS_DIR    = 12'h514;
    localparam logic [11:0] OFS_DIRSET = 12'h518;
    localparam logic [11:0] OFS_DIRCLR = 12'h51C;
    localparam logic [11:0] OFS_CFG    = 12'h700;

    localparam logic [1:0] PULL_DOWN = 2'd1;
    localparam logic [1:0] PULL_UP   = 2'd3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_OUTSET,
        SEL_OUTCLR,
        SEL_IN,
        SEL_DIR,
        SEL_DIRSET,
        SEL_DIRCLR,
        SEL_CFG
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] drive;
        logic [1:0] pull;
        logic       disc;
        logic       dir;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{drive: 3'd0, pull: 2'd0, disc: 1'b1, dir: 1'b0};

    function automatic pin_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        pin_cfg_t c;
        c.dir   = w[0];
        c.disc  = w[1];
        c.pull  = w[3:2];
        c.drive = w[10:8];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [REG_W-1:0] w;
        w       = '0;
        w[0]    = c.dir;
        w[1]    = c.disc;
        w[3:2]  = c.pull;
        w[10:8] = c.drive;
        return w;
    endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPINS  = 32,
    parameter int IDX_W  = $clog2(NPINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);

    localparam int SLOT_W = ADDR_W - 2;

    logic [ADDR_W-1:0] cfg_ofs;
    logic [SLOT_W-1:0] cfg_slot;
    logic              in_cfg;

    always_comb begin
        cfg_ofs  = addr - ADDR_W'(OFS_CFG);
        cfg_slot = cfg_ofs[ADDR_W-1:2];
        in_cfg   = (addr >= ADDR_W'(OFS_CFG)) && (cfg_ofs[1:0] == 2'b00)
                   && (cfg_slot < SLOT_W'(NPINS));
        idx      = cfg_slot[IDX_W-1:0];

        if      (addr == ADDR_W'(OFS_OUT))    sel = SEL_OUT;
        else if (addr == ADDR_W'(OFS_OUTSET)) sel = SEL_OUTSET;
        else if (addr == ADDR_W'(OFS_OUTCLR)) sel = SEL_OUTCLR;
        else if (addr == ADDR_W'(OFS_IN))     sel = SEL_IN;
        else if (addr == ADDR_W'(OFS_DIR))    sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_DIRSET)) sel = SEL_DIRSET;
        else if (addr == ADDR_W'(OFS_DIRCLR)) sel = SEL_DIRCLR;
        else if (in_cfg)                      sel = SEL_CFG;
        else                                  sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg,
    input  logic     out_bit,
    input  logic     ext_en,
    input  logic     ext_val,
    output logic     in_bit,
    output logic     oe,
    output logic     dat,
    output logic     short_flag
);

    logic drv_ok, conn, pull_en, pull_lvl;
    logic res_conn, res_lvl, in_nxt, clash;

    always_comb begin
        case (cfg.drive) inside
            [3'd0:3'd3]: drv_ok = 1'b1;
            [3'd4:3'd5]: drv_ok = out_bit;
            default:     drv_ok = ~out_bit;
        endcase
        conn     = cfg.dir & drv_ok;
        pull_en  = (cfg.pull == PULL_DOWN) || (cfg.pull == PULL_UP);
        pull_lvl = (cfg.pull == PULL_UP);

        res_conn = conn;
        res_lvl  = out_bit;
        in_nxt   = in_bit;
        clash    = 1'b0;

        if (cfg.disc) begin
            if (ext_en)  in_nxt = ext_val;
            if (pull_en) in_nxt = pull_lvl;
        end else if (ext_en) begin
            in_nxt = ext_val;
            clash  = conn & (ext_val ^ out_bit);
        end else begin
            if (pull_en && !conn) begin
                res_conn = 1'b1;
                res_lvl  = pull_lvl;
            end
            if (res_conn) in_nxt = res_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_bit     <= 1'b0;
            oe         <= 1'b0;
            dat        <= 1'b0;
            short_flag <= 1'b0;
        end else begin
            in_bit     <= in_nxt;
            oe         <= res_conn;
            dat        <= res_lvl;
            short_flag <= clash;
        end
    end

    // R8: a flagged conflict always comes with an enabled driver
    a_r8_short_has_driver: assert property (@(posedge clk) disable iff (!rst_n)
        short_flag |-> oe);

    // R5: an input-direction pin never drives unless a pull stands in
    a_r5_no_drive_as_input: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.disc || ext_en) && !cfg.dir) |=> !oe);

    // R6: disconnected buffer with a pull forces the input bit
    a_r6_disc_pull_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.disc && pull_en) |=> (in_bit == $past(pull_lvl)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPINS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [NPINS-1:0]  ext_drv_en,
    input  logic [NPINS-1:0]  ext_drv_val,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_dat,
    output logic [NPINS-1:0]  pin_short
);

    localparam int IDX_W = $clog2(NPINS);

    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic [NPINS-1:0] out_q;
    pin_cfg_t         cfg_q [NPINS];
    logic [NPINS-1:0] dir_vec;
    logic [NPINS-1:0] in_vec;
    logic [NPINS-1:0] wpins;

    assign wpins = bus_wdata[NPINS-1:0];

    gpio_reg_decode #(.ADDR_W(ADDR_W), .NPINS(NPINS), .IDX_W(IDX_W)) decode_i (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            assign dir_vec[p] = cfg_q[p].dir;
            gpio_pin_cell cell_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg        (cfg_q[p]),
                .out_bit    (out_q[p]),
                .ext_en     (ext_drv_en[p]),
                .ext_val    (ext_drv_val[p]),
                .in_bit     (in_vec[p]),
                .oe         (pin_oe[p]),
                .dat        (pin_dat[p]),
                .short_flag (pin_short[p])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int i = 0; i < NPINS; i++) cfg_q[i] <= CFG_RESET;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_OUT:    out_q <= wpins;
                SEL_OUTSET: out_q <= out_q | wpins;
                SEL_OUTCLR: out_q <= out_q & ~wpins;
                SEL_DIR:    for (int i = 0; i < NPINS; i++) cfg_q[i].dir <= wpins[i];
                SEL_DIRSET: for (int i = 0; i < NPINS; i++) if (wpins[i]) cfg_q[i].dir <= 1'b1;
                SEL_DIRCLR: for (int i = 0; i < NPINS; i++) if (wpins[i]) cfg_q[i].dir <= 1'b0;
                SEL_CFG:    cfg_q[idx] <= cfg_from_word(bus_wdata);
                SEL_IN, SEL_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            if (bus_rd) begin
                unique case (sel)
                    SEL_OUT, SEL_OUTSET, SEL_OUTCLR: bus_rdata <= REG_W'(out_q);
                    SEL_IN:                          bus_rdata <= REG_W'(in_vec);
                    SEL_DIR, SEL_DIRSET, SEL_DIRCLR: bus_rdata <= REG_W'(dir_vec);
                    SEL_CFG:                         bus_rdata <= cfg_to_word(cfg_q[idx]);
                    SEL_NONE:                        bus_err   <= 1'b1;
                endcase
            end
        end
    end

    a_r1_outset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_OUTSET) |=> ((out_q & $past(wpins)) == $past(wpins)));

    a_r1_outclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_OUTCLR) |=> ((out_q & $past(wpins)) == '0));

    a_r2_dir_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_DIR) |=> (dir_vec == $past(wpins)));

    a_r4_cfg_sets_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CFG) |=> (dir_vec[$past(idx)] == $past(bus_wdata[0])));

    a_r11_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

    localparam int NP = 32;
    localparam int P  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [NP-1:0] ext_drv_en = '0;
    logic [NP-1:0] ext_drv_val = '0;
    logic [NP-1:0] pin_oe, pin_dat, pin_short;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl #(.ADDR_W(12), .NPINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .ext_drv_en(ext_drv_en), .ext_drv_val(ext_drv_val),
        .pin_oe(pin_oe), .pin_dat(pin_dat), .pin_short(pin_short)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 pin_oe", pin_oe, '0);
        chk("R10 pin_short", pin_short, '0);
        rd(12'h504, d, e); chk("R10 out", d, 32'h0);
        rd(12'h514, d, e); chk("R10 dir", d, 32'h0);
        rd(12'h510, d, e); chk("R10 in", d, 32'h0);
        rd(12'h700, d, e); chk("R10 cfg0", d, 32'h2);
        rd(12'h77C, d, e); chk("R10 cfg31", d, 32'h2);

        // R11 unmapped reads and ignored IN write
        rd(12'h600, d, e); chk("R11 data", d, 32'h0); chk("R11 err", {31'b0, e}, 32'h1);
        rd(12'h505, d, e); chk("R11 unaligned err", {31'b0, e}, 32'h1);
        rd(12'h780, d, e); chk("R11 slot beyond err", {31'b0, e}, 32'h1);
        rd(12'h510, d, e); chk("R11 mapped no err", {31'b0, e}, 32'h0);
        wr(12'h510, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(12'h510, d, e); chk("R11 in write ignored", d, 32'h0);

        // R1 output latch aliases
        wr(12'h504, 32'h1234_5678);
        rd(12'h504, d, e); chk("R1 out write", d, 32'h1234_5678);
        wr(12'h508, 32'h0000_00F0);
        rd(12'h508, d, e); chk("R1 outset", d, 32'h1234_56F8);
        wr(12'h50C, 32'h1200_0008);
        rd(12'h50C, d, e); chk("R1 outclr", d, 32'h0034_56F0);

        // R2 direction aliases, R4 mirror
        wr(12'h514, 32'h0F0F_0000);
        rd(12'h514, d, e); chk("R2 dir write", d, 32'h0F0F_0000);
        wr(12'h518, 32'h0000_00F0);
        rd(12'h518, d, e); chk("R2 dirset", d, 32'h0F0F_00F0);
        wr(12'h51C, 32'h0F00_0000);
        rd(12'h51C, d, e); chk("R2 dirclr", d, 32'h000F_00F0);
        rd(12'h740, d, e); chk("R4 dir into cfg16", d, 32'h3);
        rd(12'h700, d, e); chk("R4 dir into cfg0", d, 32'h2);
        wr(12'h740, 32'h2);
        rd(12'h514, d, e); chk("R4 cfg16 into dir", d, 32'h000E_00F0);

        // R3 field layout, R4 set via cfg
        wr(12'h71C, 32'hFFFF_FFFF);
        rd(12'h71C, d, e); chk("R3 cfg readback", d, 32'h0000_070F);
        rd(12'h514, d, e); chk("R4 cfg7 into dir", d, 32'h000E_00F0 | 32'h80);
        wr(12'h514, 32'h0);

        // Sweep of pin P over all settings and stimuli
        for (int pre = 0; pre < 2; pre++)
        for (int dr = 0; dr < 2; dr++)
        for (int dc = 0; dc < 2; dc++)
        for (int pl = 0; pl < 4; pl++)
        for (int dm = 0; dm < 8; dm++)
        for (int ob = 0; ob < 2; ob++)
        for (int ev = 0; ev < 3; ev++) begin
            logic drv_ok, conn, pen, pv, x_oe, x_dat, x_in, x_sh;
            logic [31:0] word;
            string tin;
            // preload IN through a forcing pull
            wr(12'h700 + 12'(4 * P), pre ? 32'hE : 32'h6);
            @(negedge clk);
            ext_drv_en[P]  = (ev != 0);
            ext_drv_val[P] = (ev == 2);
            wr(12'h504, 32'(ob) << P);
            word = 32'(dr) | (32'(dc) << 1) | (32'(pl) << 2) | (32'(dm) << 8);
            wr(12'h700 + 12'(4 * P), word);
            @(negedge clk);

            drv_ok = (dm < 4) ? 1'b1 : (dm < 6) ? ob[0] : ~ob[0];
            conn   = dr[0] & drv_ok;
            pen    = (pl == 1) || (pl == 3);
            pv     = (pl == 3);
            x_sh   = 1'b0;
            x_oe   = conn;
            x_dat  = ob[0];
            if (dc != 0) begin
                x_in = pen ? pv : (ev != 0) ? (ev == 2) : pre[0];
                tin  = "R6 in";
            end else if (ev != 0) begin
                x_in = (ev == 2);
                x_sh = conn & ((ev == 2) != ob[0]);
                tin  = "R9 in";
            end else begin
                if (pen && !conn) begin x_oe = 1'b1; x_dat = pv; end
                x_in = x_oe ? x_dat : pre[0];
                tin  = "R7 in";
            end
            chk("R5 oe", {31'b0, pin_oe[P]}, {31'b0, x_oe});
            chk("R5 dat", {31'b0, pin_dat[P]}, {31'b0, x_dat});
            chk("R8 short", {31'b0, pin_short[P]}, {31'b0, x_sh});
            rd(12'h510, d, e);
            chk(tin, {31'b0, d[P]}, {31'b0, x_in});
        end

        summary();
        $finish;
    end

endmodule